// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit resolves control flow for a 32-bit integer core. Each cycle it may accept one operation: the program counter of the instruction, the two source register values, a raw immediate field and a small operation code. One clock later it returns the address to fetch next, a flag saying whether the flow was redirected, a value to write to the destination register with its write strobe, and a flag for a redirect target that is not aligned to a 4-byte boundary.

The six conditional branches compare the two register values for equality, signed order or unsigned order. Each result can be inverted. The direct jump and the register-indirect jump always redirect and produce the address of the following instruction as the link value. The PC-relative upper-immediate operation does not redirect. It returns the PC plus the immediate placed in the upper 20 bits. A decoder translates the operation code into a small set of strobes, and a datapath computes and registers the results.

Top module: `bnpc_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `taken`, `linkWe` and `misaligned` are 0, and `nextPc` and `linkVal` are 0. This holds even if `inValid` is high during reset.
- R2: A result appears on the outputs exactly one cycle after the cycle in which `inValid` was high. `outValid` is low in every cycle that does not follow an accepted operation.
- R3: `opCode` values 1 to 6 select the conditional branches. 1 redirects when rs1 equals rs2. 2 redirects when they differ. 3 redirects when rs1 is less than rs2 as signed numbers, and 4 when it is greater than or equal as signed numbers. 5 redirects when rs1 is less than rs2 as unsigned numbers, and 6 when it is greater than or equal as unsigned numbers.
- R4: The target of a taken branch is the PC plus `immField[11:0]`, sign-extended and doubled. This reaches -4096 to +4094 bytes. A branch never writes a link value (`linkWe` is 0, `linkVal` is 0).
- R5: In three cases `nextPc` is PC+4 and `taken` is 0: a branch that is not taken, `opCode` 0, and the unused codes 10 to 15. Codes 0 and 10 to 15 also leave `linkWe` at 0.
- R6: `opCode` 7 (direct jump) redirects to the PC plus `immField[19:0]`, sign-extended and doubled. This reaches -1 MiB to +1 MiB minus 2. It sets `linkWe` and `linkVal` = PC+4.
- R7: `opCode` 8 (register-indirect jump) redirects to rs1 plus `immField[11:0]` sign-extended, with bit 0 of the sum cleared. It sets `linkWe` and `linkVal` = PC+4.
- R8: `opCode` 9 (PC-relative upper immediate) sets `linkWe` and `linkVal` = PC + (`immField[19:0]` << 12). `taken` is 0 and `nextPc` is PC+4.
- R9: `misaligned` is 1 exactly when `taken` is 1 and bit 1 of `nextPc` is 1.
- R10: All additions for targets, PC+4 and link values wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Control-flow operation code |
| pcIn | input | 32 | PC of the operation |
| rs1Val | input | 32 | First source register value |
| rs2Val | input | 32 | Second source register value |
| immField | input | 20 | Raw immediate; low 12 bits for branches and the indirect jump |
| outValid | output | 1 | Result valid |
| nextPc | output | 32 | Next fetch address |
| taken | output | 1 | Flow redirected |
| linkWe | output | 1 | Destination write strobe |
| linkVal | output | 32 | Value for the destination register |
| misaligned | output | 1 | Redirect target not 4-byte aligned |

## Verification
The embedded properties check, on every cycle, that the one-cycle valid timing holds and that a fall-through result is PC+4. They also check that jumps always link PC+4 and that the indirect target has bit 0 clear. The misalignment flag is checked to match the taken flag and target bit 1, and branches are checked never to write a link value. The compare semantics, the scaled and sign-extended offsets at their extreme values, the upper-immediate sum and wraparound past the top of the address space all depend on arithmetic against the inputs. Only the bench scenarios show these, by comparing each result with an independently computed expectation.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 4'd0,
    OP_BEQ   = 4'd1,
    OP_BNE   = 4'd2,
    OP_BLT   = 4'd3,
    OP_BGE   = 4'd4,
    OP_BLTU  = 4'd5,
    OP_BGEU  = 4'd6,
    OP_JDIR  = 4'd7,
    OP_JIND  = 4'd8,
    OP_UPPC  = 4'd9
  } flowOp_e;

  // Strobes passed from the decoder to the datapath
  typedef struct packed {
    logic isBranch;  // conditional redirect
    logic isJal;     // PC-relative jump with link
    logic isJalr;    // register-indirect jump with link
    logic isUpper;   // PC plus upper immediate, no redirect
    logic cmpLt;     // use ordered compare instead of equality
    logic cmpUns;    // ordered compare is unsigned
    logic cmpNeg;    // invert the compare outcome
  } flowStb_t;

endpackage

// File: rtl/bnpc_sext.sv
module bnpc_sext #(
  parameter int IN_W  = 12,
  parameter int SHL   = 1,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] ext
);

  logic [OUT_W-1:0] widened;

  generate
    if (IN_W < OUT_W) begin : g_extend
      assign widened = {{(OUT_W-IN_W){raw[IN_W-1]}}, raw};
    end else begin : g_trunc
      assign widened = raw[OUT_W-1:0];
    end
  endgenerate

  assign ext = widened << SHL;

endmodule

// File: rtl/bnpc_ctrl.sv
module bnpc_ctrl
  import bnpc_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output flowStb_t        stb
);

  flowOp_e op;
  assign op = flowOp_e'(opCode);

  always_comb begin
    stb = '0;
    unique case (op)
      OP_BEQ:  begin stb.isBranch = 1'b1; end
      OP_BNE:  begin stb.isBranch = 1'b1; stb.cmpNeg = 1'b1; end
      OP_BLT:  begin stb.isBranch = 1'b1; stb.cmpLt = 1'b1; end
      OP_BGE:  begin stb.isBranch = 1'b1; stb.cmpLt = 1'b1; stb.cmpNeg = 1'b1; end
      OP_BLTU: begin stb.isBranch = 1'b1; stb.cmpLt = 1'b1; stb.cmpUns = 1'b1; end
      OP_BGEU: begin
        stb.isBranch = 1'b1; stb.cmpLt = 1'b1; stb.cmpUns = 1'b1; stb.cmpNeg = 1'b1;
      end
      OP_JDIR: begin stb.isJal = 1'b1; end
      OP_JIND: begin stb.isJalr = 1'b1; end
      OP_UPPC: begin stb.isUpper = 1'b1; end
      default: begin stb = '0; end
    endcase
  end

endmodule

// File: rtl/bnpc_dp.sv
module bnpc_dp
  import bnpc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int BR_IMM_W = 12,
  parameter int J_IMM_W  = 20,
  parameter int I_IMM_W  = 12,
  parameter int U_SHIFT  = 12,
  parameter int STEP     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  flowStb_t           stb,
  input  logic [XLEN-1:0]    pcIn,
  input  logic [XLEN-1:0]    rs1Val,
  input  logic [XLEN-1:0]    rs2Val,
  input  logic [J_IMM_W-1:0] immField,
  output logic               outValid,
  output logic [XLEN-1:0]    nextPc,
  output logic               taken,
  output logic               linkWe,
  output logic [XLEN-1:0]    linkVal,
  output logic               misaligned
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] brOff, jOff, iOff, upOff;
  logic [XLEN-1:0] seqPc, jalrSum, jalrTgt, target;
  logic            eqHit, ltHit, condHit, takeNow;
  logic [XLEN-1:0] nextCalc, linkCalc;
  logic            linkWeCalc, misCalc;

  bnpc_sext #(.IN_W(BR_IMM_W), .SHL(1), .OUT_W(XLEN)) u_brOff (
    .raw(immField[BR_IMM_W-1:0]), .ext(brOff));
  bnpc_sext #(.IN_W(J_IMM_W), .SHL(1), .OUT_W(XLEN)) u_jOff (
    .raw(immField), .ext(jOff));
  bnpc_sext #(.IN_W(I_IMM_W), .SHL(0), .OUT_W(XLEN)) u_iOff (
    .raw(immField[I_IMM_W-1:0]), .ext(iOff));
  bnpc_sext #(.IN_W(J_IMM_W), .SHL(U_SHIFT), .OUT_W(XLEN)) u_upOff (
    .raw(immField), .ext(upOff));

  // Compare: one equality and one ordered compare shared by all six branches
  always_comb begin
    eqHit   = (rs1Val == rs2Val);
    ltHit   = stb.cmpUns ? (rs1Val < rs2Val) : ($signed(rs1Val) < $signed(rs2Val));
    condHit = (stb.cmpLt ? ltHit : eqHit) ^ stb.cmpNeg;
  end

  // Target selection
  always_comb begin
    seqPc   = pcIn + STEP_V;
    jalrSum = rs1Val + iOff;
    jalrTgt = {jalrSum[XLEN-1:1], 1'b0};
    if (stb.isJalr)     target = jalrTgt;
    else if (stb.isJal) target = pcIn + jOff;
    else                target = pcIn + brOff;
    takeNow    = stb.isJal | stb.isJalr | (stb.isBranch & condHit);
    nextCalc   = takeNow ? target : seqPc;
    linkWeCalc = stb.isJal | stb.isJalr | stb.isUpper;
    if (stb.isUpper)                 linkCalc = pcIn + upOff;
    else if (stb.isJal | stb.isJalr) linkCalc = seqPc;
    else                             linkCalc = '0;
    misCalc = takeNow & target[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      nextPc     <= '0;
      taken      <= 1'b0;
      linkWe     <= 1'b0;
      linkVal    <= '0;
      misaligned <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        nextPc     <= nextCalc;
        taken      <= takeNow;
        linkWe     <= linkWeCalc;
        linkVal    <= linkCalc;
        misaligned <= misCalc;
      end
    end
  end

  // Decoder strobes never select two operation classes at once
  p_stb_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.isBranch, stb.isJal, stb.isJalr, stb.isUpper}));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid)) |-> outValid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid);

  p_fallthru_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !taken) |-> (nextPc == $past(pcIn) + STEP_V));

  p_branch_nolink_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(stb.isBranch)) |-> (!linkWe && linkVal == '0));

  p_jump_link_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(stb.isJal || stb.isJalr)) |->
      (taken && linkWe && linkVal == $past(pcIn) + STEP_V));

  p_ind_lsb_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(stb.isJalr)) |-> !nextPc[0]);

  p_upper_flow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(stb.isUpper)) |-> (linkWe && !taken));

  p_misalign_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (misaligned == (taken && nextPc[1])));

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int BR_IMM_W = 12,
  parameter int J_IMM_W  = 20,
  parameter int I_IMM_W  = 12,
  parameter int U_SHIFT  = 12,
  parameter int STEP     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [OP_W-1:0]    opCode,
  input  logic [XLEN-1:0]    pcIn,
  input  logic [XLEN-1:0]    rs1Val,
  input  logic [XLEN-1:0]    rs2Val,
  input  logic [J_IMM_W-1:0] immField,
  output logic               outValid,
  output logic [XLEN-1:0]    nextPc,
  output logic               taken,
  output logic               linkWe,
  output logic [XLEN-1:0]    linkVal,
  output logic               misaligned
);

  flowStb_t stb;

  bnpc_ctrl u_ctrl (
    .opCode(opCode),
    .stb   (stb)
  );

  bnpc_dp #(
    .XLEN(XLEN), .BR_IMM_W(BR_IMM_W), .J_IMM_W(J_IMM_W),
    .I_IMM_W(I_IMM_W), .U_SHIFT(U_SHIFT), .STEP(STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .stb       (stb),
    .pcIn      (pcIn),
    .rs1Val    (rs1Val),
    .rs2Val    (rs2Val),
    .immField  (immField),
    .outValid  (outValid),
    .nextPc    (nextPc),
    .taken     (taken),
    .linkWe    (linkWe),
    .linkVal   (linkVal),
    .misaligned(misaligned)
  );

endmodule

// File: tb/sim_bnpc_unit.sv
`timescale 1ns/1ps
module sim_bnpc_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [3:0]  opCode;
  logic [31:0] pcIn, rs1Val, rs2Val;
  logic [19:0] immField;
  logic        outValid, taken, linkWe, misaligned;
  logic [31:0] nextPc, linkVal;

  always #5 clk = ~clk;

  bnpc_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .pcIn(pcIn), .rs1Val(rs1Val), .rs2Val(rs2Val), .immField(immField),
    .outValid(outValid), .nextPc(nextPc), .taken(taken), .linkWe(linkWe),
    .linkVal(linkVal), .misaligned(misaligned)
  );

  typedef struct packed {
    logic [31:0] nxt;
    logic        tk;
    logic        lwe;
    logic [31:0] lnk;
    logic        mis;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  function automatic expItem_t refModel(input logic [3:0] op, input logic [31:0] pc,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [19:0] imm);
    expItem_t e;
    logic [31:0] brO, jO, iO, seq, t;
    logic cond;
    brO  = {{19{imm[11]}}, imm[11:0], 1'b0};
    jO   = {{11{imm[19]}}, imm, 1'b0};
    iO   = {{20{imm[11]}}, imm[11:0]};
    seq  = pc + 32'd4;
    cond = 1'b0;
    e    = '0;
    e.nxt = seq;
    case (op)
      4'd1: cond = (a == b);
      4'd2: cond = (a != b);
      4'd3: cond = ($signed(a) <  $signed(b));
      4'd4: cond = ($signed(a) >= $signed(b));
      4'd5: cond = (a <  b);
      4'd6: cond = (a >= b);
      default: cond = 1'b0;
    endcase
    if (op >= 4'd1 && op <= 4'd6) begin
      e.tk = cond;
      if (cond) e.nxt = pc + brO;
    end else if (op == 4'd7) begin
      e.tk = 1'b1; e.nxt = pc + jO; e.lwe = 1'b1; e.lnk = seq;
    end else if (op == 4'd8) begin
      t = a + iO; t[0] = 1'b0;
      e.tk = 1'b1; e.nxt = t; e.lwe = 1'b1; e.lnk = seq;
    end else if (op == 4'd9) begin
      e.lwe = 1'b1; e.lnk = pc + {imm, 12'h000};
    end
    e.mis = e.tk & e.nxt[1];
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic [31:0] pc, input logic [31:0] a,
                      input logic [31:0] b, input logic [19:0] imm, input string tag);
    @(negedge clk);
    inValid  = 1'b1;
    opCode   = op;
    pcIn     = pc;
    rs1Val   = a;
    rs2Val   = b;
    immField = imm;
    expQ.push_back(refModel(op, pc, a, b, imm));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: compare each valid result with the front of the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && outValid) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R2: result with no pending operation, nextPc=%h expected none", nextPc);
        end else begin
          expItem_t e;
          string tg;
          e  = expQ.pop_front();
          tg = tagQ.pop_front();
          if (nextPc !== e.nxt || taken !== e.tk || linkWe !== e.lwe ||
              linkVal !== e.lnk || misaligned !== e.mis) begin
            fails++;
            $display("FAIL %s: got nxt=%h tk=%b lwe=%b lnk=%h mis=%b expected nxt=%h tk=%b lwe=%b lnk=%h mis=%b",
                     tg, nextPc, taken, linkWe, linkVal, misaligned,
                     e.nxt, e.tk, e.lwe, e.lnk, e.mis);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got running expected done");
      report();
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b1; opCode = 4'd7; pcIn = 32'h0000_1000;
    rs1Val = '0; rs2Val = '0; immField = 20'h00010;
    repeat (3) @(negedge clk);
    // R1: reset state holds despite an operation presented during reset
    checks++;
    if (outValid !== 1'b0 || taken !== 1'b0 || linkWe !== 1'b0 || misaligned !== 1'b0 ||
        nextPc !== 32'h0 || linkVal !== 32'h0) begin
      fails++;
      $display("FAIL R1: got v=%b nxt=%h tk=%b lwe=%b lnk=%h mis=%b expected all zero",
               outValid, nextPc, taken, linkWe, linkVal, misaligned);
    end
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R5: no operation and unused codes fall through
    send(4'd0,  32'h0000_0100, 32'h5, 32'h5, 20'h00010, "R5 none");
    send(4'd12, 32'h0000_0200, 32'h5, 32'h5, 20'h00010, "R5 unused code");
    // R3/R4: equality pair, back to back
    send(4'd1, 32'h0000_1000, 32'h1234, 32'h1234, 20'h00008, "R3 eq taken");
    send(4'd1, 32'h0000_1000, 32'h1234, 32'h1235, 20'h00008, "R3 eq not taken");
    send(4'd2, 32'h0000_1000, 32'h1, 32'h2, 20'h00FFC, "R3 ne taken");
    send(4'd2, 32'h0000_1000, 32'h7, 32'h7, 20'h00FFC, "R3 ne not taken");
    idle(1);
    // R3: signed against unsigned on the same operands
    send(4'd3, 32'h0000_2000, 32'hFFFF_FFFF, 32'h1, 20'h00010, "R3 signed lt taken");
    send(4'd5, 32'h0000_2000, 32'hFFFF_FFFF, 32'h1, 20'h00010, "R3 unsigned lt not taken");
    send(4'd4, 32'h0000_2000, 32'h8000_0000, 32'h8000_0000, 20'h00010, "R3 signed ge equal");
    send(4'd4, 32'h0000_2000, 32'h8000_0000, 32'h0, 20'h00010, "R3 signed ge not taken");
    send(4'd6, 32'h0000_2000, 32'h8000_0000, 32'h0, 20'h00010, "R3 unsigned ge taken");
    send(4'd6, 32'h0000_2000, 32'h0, 32'h1, 20'h00010, "R3 unsigned ge not taken");
    // R4: branch offset extremes
    send(4'd1, 32'h0001_0000, 32'h0, 32'h0, 20'h007FF, "R4 max forward");
    send(4'd1, 32'h0001_0000, 32'h0, 32'h0, 20'h00800, "R4 max backward");
    // R6: direct jump extremes
    send(4'd7, 32'h0020_0000, 32'h0, 32'h0, 20'h7FFFF, "R6 max forward");
    send(4'd7, 32'h0020_0000, 32'h0, 32'h0, 20'h80000, "R6 max backward");
    idle(2);
    // R7: indirect jump clears bit 0, negative offset
    send(4'd8, 32'h0000_3000, 32'h0000_4001, 32'h0, 20'h00FF0, "R7 odd sum");
    send(4'd8, 32'h0000_3000, 32'h0000_4000, 32'h0, 20'h00003, "R7 bit0 cleared");
    // R9: misalignment only on a taken target with bit 1 set
    send(4'd8, 32'h0000_3000, 32'h0000_4000, 32'h0, 20'h00002, "R9 indirect misaligned");
    send(4'd1, 32'h0000_0100, 32'h3, 32'h3, 20'h00001, "R9 branch misaligned");
    send(4'd1, 32'h0000_0100, 32'h3, 32'h4, 20'h00001, "R9 not taken not flagged");
    // R8: upper immediate
    send(4'd9, 32'h0000_4004, 32'h9, 32'h9, 20'h12345, "R8 upper add");
    // R10: wrap modulo 2^32
    send(4'd9, 32'hFFFF_F000, 32'h0, 32'h0, 20'h00001, "R10 upper wrap");
    send(4'd7, 32'hFFFF_FFFC, 32'h0, 32'h0, 20'h00002, "R10 link and target wrap");
    send(4'd0, 32'hFFFF_FFFC, 32'h0, 32'h0, 20'h00000, "R10 fallthrough wrap");
    send(4'd8, 32'h0, 32'hFFFF_FFFF, 32'h0, 20'h00005, "R10 indirect wrap");

    idle(3);
    // R2: no result without a pending operation, all expected results seen
    checks++;
    if (outValid !== 1'b0 || expQ.size() != 0) begin
      fails++;
      $display("FAIL R2: got outValid=%b pending=%0d expected outValid=0 pending=0",
               outValid, expQ.size());
    end
    finished = 1'b1;
    report();
  end

endmodule